// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare

This block is a memory-mapped countdown timer. Software programs a starting value, a compare value and a control word over a simple word-addressed register port. The counter then steps down by one on each divided tick. At zero it either reloads the programmed value or restarts from all-ones. When the count meets the compare value, it sets a sticky flag, and that flag drives a level interrupt.

Ticks come from one of three external tick-enable inputs, chosen by a two-bit source field, or from none. A 12-bit prescaler sits between the chosen input and the counter. Writes to the load register can optionally overwrite the running count at once. A software reset bit in the control word clears the run-time state but keeps the configuration fields. The low-power and debug bits are stored and read back only.

Top module: `cmp_down_timer`

## Requirements
- R1: Registers sit at word offsets 0 (control), 1 (status), 2 (load), 3 (compare) and 4 (count). A read of any other offset returns 0.
- R2: After the synchronous reset, control, status, compare and count read 0, load reads 0xFFFFFFFF, and the interrupt is low.
- R3: A control write stores bits 25:0 and drops bits 31:26. Bit 16 (software reset) always reads back 0. Bits 0 (run), 1 (fresh-start), 2 (compare interrupt enable), 3 (reload mode), 15:4 (prescale), 17 (immediate overwrite), 18 to 21 (stored-only power/debug enables), 23:22 (spare) and 25:24 (tick source) read back as written.
- R4: The tick source encoding is: 00 = no ticks, 01 = src_tick_i[0], 10 = src_tick_i[1], 11 = src_tick_i[2]. Pulses on the lines that are not selected have no effect on the count.
- R5: With prescale value P, the counter steps once per P+1 pulses of the selected source. The prescaler restarts when the run bit rises.
- R6: While running, each tick lowers a nonzero count by one. A tick at count 0 loads the load value if reload mode is set, and 0xFFFFFFFF otherwise. Without a tick or a register write, the count holds.
- R7: A load write always updates the load register. It also replaces the count in the same cycle only when the overwrite bit is already set.
- R8: When the run bit rises with fresh-start set, the count becomes the load value (reload mode) or 0xFFFFFFFF. With fresh-start clear, the count resumes from its held value.
- R9: Writing status with bit 0 = 1 clears the compare flag. Writing bit 0 = 0 leaves it unchanged.
- R10: irq_o equals the compare flag ANDed with control bit 2. Clearing bit 2 masks irq_o without clearing the flag.
- R11: With a nonzero compare value and bit 2 set, the flag sets on the tick that brings the count to the compare value, and on no other tick.
- R12: With a compare value of 0 and bit 2 set, the flag sets on the tick that wraps the count from 0. Reaching 0 does not set it.
- R13: A control write with bit 16 set stores the written word with bits 0, 1 and 18 to 21 forced to 0. It also clears status, count and compare, and sets load to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_tick_i | input | 3 | Tick-enable pulses of the three selectable sources |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Level compare interrupt |

## Verification
The countdown is swept tick by tick through several full reload periods, so the bench can catch an off-by-one in the hold-at-zero step or a wrong reload value. Prescale values 0 to 3 are each run against the same pulse train, which separates division by P from division by P+1. Every source code is driven with pulses on all three lines, so a wrong selection mapping shows up. Compare values are tried as nonzero and as zero across full periods, which tells a match on arrival apart from a match at the wrap, and a masked interrupt apart from a cleared flag.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int CDT_PRE_W  = 12;
    localparam int CDT_CTRL_W = 26;

    localparam int OFF_CTRL = 0;
    localparam int OFF_STAT = 1;
    localparam int OFF_LOAD = 2;
    localparam int OFF_CMP  = 3;
    localparam int OFF_CNT  = 4;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_MAIN = 2'b01,
        SRC_FAST = 2'b10,
        SRC_SLOW = 2'b11
    } clk_src_e;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_STAT,
        SEL_LOAD,
        SEL_CMP,
        SEL_CNT,
        SEL_NONE
    } reg_sel_e;

    // Control word layout, MSB first (bit 25 down to bit 0)
    typedef struct packed {
        clk_src_e               clk_src;   // 25:24
        logic [1:0]             spare;     // 23:22
        logic                   stop_en;   // 21
        logic                   doze_en;   // 20
        logic                   wait_en;   // 19
        logic                   dbg_en;    // 18
        logic                   ovw_en;    // 17
        logic                   swr;       // 16
        logic [CDT_PRE_W-1:0]   prescale;  // 15:4
        logic                   rld;       // 3
        logic                   ocien;     // 2
        logic                   enmod;     // 1
        logic                   en;        // 0
    } ctrl_t;

    // Value stored by a control write; a software reset drops the run-time enables
    function automatic ctrl_t ctrl_from_write(input logic [CDT_CTRL_W-1:0] wd);
        ctrl_t c;
        c = ctrl_t'(wd);
        if (c.swr) begin
            c.en      = 1'b0;
            c.enmod   = 1'b0;
            c.stop_en = 1'b0;
            c.doze_en = 1'b0;
            c.wait_en = 1'b0;
            c.dbg_en  = 1'b0;
        end
        c.swr = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                flag_i,
    output ctrl_t               ctrl_o,
    output logic [CNT_W-1:0]    load_o,
    output logic [CNT_W-1:0]    cmp_o,
    output logic                swr_o,
    output logic                en_rise_o,
    output logic                restart_o,
    output logic [CNT_W-1:0]    restart_val_o,
    output logic                load_wr_o,
    output logic                clr_o,
    output logic [DATA_W-1:0]   rdata_o
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    reg_sel_e           sel;
    ctrl_t              ctrl_q;
    ctrl_t              ctrl_new;
    logic [CNT_W-1:0]   load_q;
    logic [CNT_W-1:0]   cmp_q;
    logic               ctrl_wr;

    always_comb begin
        sel = SEL_NONE;
        if      (addr_i == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
        else if (addr_i == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
        else if (addr_i == ADDR_W'(OFF_LOAD)) sel = SEL_LOAD;
        else if (addr_i == ADDR_W'(OFF_CMP))  sel = SEL_CMP;
        else if (addr_i == ADDR_W'(OFF_CNT))  sel = SEL_CNT;
    end

    assign ctrl_new      = ctrl_from_write(wdata_i[CDT_CTRL_W-1:0]);
    assign ctrl_wr       = we_i && (sel == SEL_CTRL);
    assign swr_o         = ctrl_wr && wdata_i[16];
    assign en_rise_o     = ctrl_wr && !ctrl_q.en && ctrl_new.en;
    assign restart_o     = en_rise_o && ctrl_new.enmod;
    assign restart_val_o = ctrl_new.rld ? load_q : ALL_ONES;
    assign load_wr_o     = we_i && (sel == SEL_LOAD);
    assign clr_o         = we_i && (sel == SEL_STAT) && wdata_i[0];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '0;
            load_q <= ALL_ONES;
            cmp_q  <= '0;
        end else if (we_i) begin
            case (sel)
                SEL_CTRL: begin
                    ctrl_q <= ctrl_new;
                    if (wdata_i[16]) begin
                        load_q <= ALL_ONES;
                        cmp_q  <= '0;
                    end
                end
                SEL_LOAD: load_q <= wdata_i[CNT_W-1:0];
                SEL_CMP:  cmp_q  <= wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata_o = {{(DATA_W-CDT_CTRL_W){1'b0}}, ctrl_q};
            SEL_STAT: rdata_o = {{(DATA_W-1){1'b0}}, flag_i};
            SEL_LOAD: rdata_o = DATA_W'(load_q);
            SEL_CMP:  rdata_o = DATA_W'(cmp_q);
            SEL_CNT:  rdata_o = DATA_W'(cnt_i);
            default:  rdata_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign load_o = load_q;
    assign cmp_o  = cmp_q;

endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale
    import cdt_pkg::*;
#(
    parameter int PRE_W   = CDT_PRE_W,
    parameter int N_SRC   = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                run_i,
    input  logic                restart_i,
    input  clk_src_e            src_sel_i,
    input  logic [N_SRC-1:0]    src_tick_i,
    input  logic [PRE_W-1:0]    div_i,
    output logic                tick_o
);

    logic [PRE_W-1:0]   pcnt_q;
    logic [N_SRC:0]     src_ext;
    logic               pulse;

    // Code 0 selects a constant-low line; codes 1..N_SRC select the inputs
    assign src_ext = {src_tick_i, 1'b0};
    assign pulse   = src_ext[src_sel_i];
    assign tick_o  = run_i && pulse && (pcnt_q >= div_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            pcnt_q <= '0;
        end else if (run_i && pulse) begin
            pcnt_q <= tick_o ? '0 : pcnt_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/cdt_core.sv
module cdt_core #(
    parameter int CNT_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                tick_i,
    input  logic                swr_i,
    input  logic                restart_i,
    input  logic [CNT_W-1:0]    restart_val_i,
    input  logic                load_wr_i,
    input  logic [CNT_W-1:0]    load_val_i,
    input  logic                ovw_i,
    input  logic                rld_i,
    input  logic                ocien_i,
    input  logic [CNT_W-1:0]    load_i,
    input  logic [CNT_W-1:0]    cmp_i,
    input  logic                clr_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                flag_o
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   nxt;
    logic               wrap;
    logic               hit;
    logic               flag_q;

    assign wrap = (cnt_q == '0);
    assign nxt  = wrap ? (rld_i ? load_i : ALL_ONES) : cnt_q - CNT_W'(1);
    assign hit  = tick_i && ocien_i &&
                  ((cmp_i == '0) ? wrap : (nxt == cmp_i));

    always_ff @(posedge clk_i) begin
        if (rst_i || swr_i) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (load_wr_i && ovw_i)  cnt_q <= load_val_i;
            else if (restart_i)      cnt_q <= restart_val_i;
            else if (tick_i)         cnt_q <= nxt;

            if (hit)                 flag_q <= 1'b1;
            else if (clr_i)          flag_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/cmp_down_timer.sv
module cmp_down_timer
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4,
    parameter int N_SRC  = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [N_SRC-1:0]    src_tick_i,
    input  logic                reg_we_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);

    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   load_q;
    logic [CNT_W-1:0]   cmp_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   restart_val;
    logic               flag;
    logic               swr;
    logic               en_rise;
    logic               restart;
    logic               load_wr;
    logic               clr;
    logic               tick;

    cdt_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .we_i           (reg_we_i),
        .addr_i         (reg_addr_i),
        .wdata_i        (reg_wdata_i),
        .cnt_i          (cnt_q),
        .flag_i         (flag),
        .ctrl_o         (ctrl_q),
        .load_o         (load_q),
        .cmp_o          (cmp_q),
        .swr_o          (swr),
        .en_rise_o      (en_rise),
        .restart_o      (restart),
        .restart_val_o  (restart_val),
        .load_wr_o      (load_wr),
        .clr_o          (clr),
        .rdata_o        (reg_rdata_o)
    );

    cdt_prescale #(
        .PRE_W  (CDT_PRE_W),
        .N_SRC  (N_SRC)
    ) u_pre (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .run_i      (ctrl_q.en),
        .restart_i  (en_rise || swr),
        .src_sel_i  (ctrl_q.clk_src),
        .src_tick_i (src_tick_i),
        .div_i      (ctrl_q.prescale),
        .tick_o     (tick)
    );

    cdt_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .tick_i         (tick),
        .swr_i          (swr),
        .restart_i      (restart),
        .restart_val_i  (restart_val),
        .load_wr_i      (load_wr),
        .load_val_i     (reg_wdata_i[CNT_W-1:0]),
        .ovw_i          (ctrl_q.ovw_en),
        .rld_i          (ctrl_q.rld),
        .ocien_i        (ctrl_q.ocien),
        .load_i         (load_q),
        .cmp_i          (cmp_q),
        .clr_i          (clr),
        .cnt_o          (cnt_q),
        .flag_o         (flag)
    );

    assign irq_o = flag && ctrl_q.ocien;

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                ovw_i,
    input  logic                tick_i,
    input  logic [1:0]          src_sel_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                irq_i
);

    a_r13_swr_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && addr_i == ADDR_W'(0) && wdata_i[16]) |=> (cnt_i == '0 && !irq_i));

    a_r7_overwrite: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && addr_i == ADDR_W'(2) && ovw_i) |=> (cnt_i == $past(wdata_i[CNT_W-1:0])));

    a_r6_hold_no_tick: assert property (@(posedge clk_i) disable iff (rst_i)
        (!we_i && !tick_i) |=> $stable(cnt_i));

    a_r6_step_down: assert property (@(posedge clk_i) disable iff (rst_i)
        (!we_i && tick_i && cnt_i != '0) |=> (cnt_i == CNT_W'($past(cnt_i) - CNT_W'(1))));

    a_r9_clear_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && addr_i == ADDR_W'(1) && wdata_i[0] && !tick_i) |=> !irq_i);

    a_r4_source_off: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_sel_i == 2'b00) |-> !tick_i);

endmodule

bind cmp_down_timer cdt_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .ovw_i      (ctrl_q.ovw_en),
    .tick_i     (tick),
    .src_sel_i  (ctrl_q.clk_src),
    .cnt_i      (cnt_q),
    .irq_i      (irq_o)
);

// File: tb/test_cmp_down_timer.sv
module test_cmp_down_timer;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] B_EN    = 32'h1;
    localparam logic [31:0] B_FRESH = 32'h2;
    localparam logic [31:0] B_IE    = 32'h4;
    localparam logic [31:0] B_RLD   = 32'h8;
    localparam logic [31:0] B_SWR   = 32'h1_0000;
    localparam logic [31:0] B_OVW   = 32'h2_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    cmp_down_timer i_cmp_down_timer (
        .clk_i       (clk),
        .rst_i       (rst),
        .src_tick_i  (src),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] src_code(input int s);
        return 32'(s) << 24;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 4'(a);
        #1;
        d = rdata;
    endtask

    task automatic pulses(input logic [2:0] m, input int n);
        repeat (n) begin
            @(negedge clk); src = m;
            @(negedge clk); src = '0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cw;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2 reset values, R1 map and unmapped offsets
        rd(0, v); chk("R2 ctrl", v, 32'h0);
        rd(1, v); chk("R2 status", v, 32'h0);
        rd(2, v); chk("R2 load", v, 32'hFFFF_FFFF);
        rd(3, v); chk("R2 cmp", v, 32'h0);
        rd(4, v); chk("R2 count", v, 32'h0);
        chk("R2 irq", {31'b0, irq}, 32'h0);
        for (int a = 5; a < 16; a++) begin
            rd(a, v); chk("R1 unmapped", v, 32'h0);
        end
        wr(3, 32'h1234); rd(3, v); chk("R1 cmp offset", v, 32'h1234);
        wr(3, 32'h0);

        // R8 fresh start, R6 reload sweep over several periods
        wr(2, 32'd10);
        wr(0, B_EN | B_FRESH | B_RLD | src_code(1));
        rd(4, v); chk("R8 fresh from load", v, 32'd10);
        for (int n = 1; n <= 25; n++) begin
            pulses(3'b001, 1);
            rd(4, v); chk("R6 reload sweep", v, 32'(10 - (n % 11)));
        end

        // R5 prescale sweep
        for (int p = 0; p < 4; p++) begin
            wr(0, B_FRESH | B_RLD | src_code(1) | (32'(p) << 4));
            wr(2, 32'd100);
            wr(0, B_EN | B_FRESH | B_RLD | src_code(1) | (32'(p) << 4));
            pulses(3'b001, 7);
            rd(4, v); chk("R5 prescale", v, 32'(100 - 7 / (p + 1)));
        end

        // R4 source selection
        wr(0, B_FRESH | B_RLD);
        wr(2, 32'd50);
        wr(0, B_EN | B_FRESH | B_RLD | src_code(0));
        pulses(3'b111, 4);
        rd(4, v); chk("R4 source off", v, 32'd50);
        for (int s = 1; s < 4; s++) begin
            wr(0, B_FRESH | B_RLD | src_code(s));
            wr(0, B_EN | B_FRESH | B_RLD | src_code(s));
            for (int b = 0; b < 3; b++) pulses(3'(1 << b), 2);
            rd(4, v); chk("R4 source select", v, 32'd48);
        end

        // R8 start from all-ones, R7 overwrite, R6 non-reload wrap
        wr(0, B_FRESH | src_code(1));
        wr(0, B_EN | B_FRESH | src_code(1));
        rd(4, v); chk("R8 fresh all-ones", v, 32'hFFFF_FFFF);
        wr(2, 32'd2);
        rd(4, v); chk("R7 no overwrite", v, 32'hFFFF_FFFF);
        rd(2, v); chk("R7 load stored", v, 32'd2);
        wr(0, B_EN | B_FRESH | B_OVW | src_code(1));
        wr(2, 32'd2);
        rd(4, v); chk("R7 overwrite", v, 32'd2);
        pulses(3'b001, 2);
        rd(4, v); chk("R6 reach zero", v, 32'd0);
        pulses(3'b001, 1);
        rd(4, v); chk("R6 wrap all-ones", v, 32'hFFFF_FFFF);

        // R8 resume with fresh-start clear
        pulses(3'b001, 3);
        wr(0, B_FRESH | src_code(1));
        pulses(3'b001, 3);
        rd(4, v); chk("R6 hold while stopped", v, 32'hFFFF_FFFC);
        wr(0, B_EN | src_code(1));
        rd(4, v); chk("R8 resume held", v, 32'hFFFF_FFFC);
        pulses(3'b001, 1);
        rd(4, v); chk("R8 resume count", v, 32'hFFFF_FFFB);

        // R11 nonzero compare, R9 clear, R10 masking
        wr(0, B_FRESH | B_RLD | B_IE | src_code(1));
        wr(1, 32'h1);
        wr(3, 32'd3);
        wr(2, 32'd5);
        wr(0, B_EN | B_FRESH | B_RLD | B_IE | src_code(1));
        pulses(3'b001, 1);
        rd(1, v); chk("R11 no early flag", v, 32'h0);
        pulses(3'b001, 1);
        rd(1, v); chk("R11 flag on match", v, 32'h1);
        chk("R10 irq on", {31'b0, irq}, 32'h1);
        wr(1, 32'h0);
        rd(1, v); chk("R9 write zero keeps", v, 32'h1);
        wr(0, B_EN | B_FRESH | B_RLD | src_code(1));
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        rd(1, v); chk("R10 flag kept", v, 32'h1);
        wr(0, B_EN | B_FRESH | B_RLD | B_IE | src_code(1));
        chk("R10 irq unmasked", {31'b0, irq}, 32'h1);
        wr(1, 32'h1);
        rd(1, v); chk("R9 write one clears", v, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);
        pulses(3'b001, 4);
        rd(1, v); chk("R11 no flag off match", v, 32'h0);
        pulses(3'b001, 2);
        rd(1, v); chk("R11 flag next period", v, 32'h1);

        // R12 zero compare fires at wrap only
        wr(0, B_FRESH | B_RLD | B_IE | src_code(1));
        wr(1, 32'h1);
        wr(3, 32'd0);
        wr(2, 32'd2);
        wr(0, B_EN | B_FRESH | B_RLD | B_IE | src_code(1));
        pulses(3'b001, 2);
        rd(4, v); chk("R12 count zero", v, 32'd0);
        rd(1, v); chk("R12 no flag at zero", v, 32'h0);
        pulses(3'b001, 1);
        rd(1, v); chk("R12 flag at wrap", v, 32'h1);
        rd(4, v); chk("R12 reloaded", v, 32'd2);

        // R3 control storage, R13 software reset
        cw = 32'hFC00_0000 | src_code(2) | (32'h3 << 22) | (32'hF << 18) | B_OVW
             | (32'hABC << 4) | 32'hF;
        wr(0, cw);
        rd(0, v); chk("R3 control stored", v, cw & 32'h03FF_FFFF);
        wr(3, 32'd7);
        wr(2, 32'd9);
        wr(0, cw | B_SWR);
        rd(0, v);
        chk("R13 control kept bits", v, (cw & 32'h03FF_FFFF) & ~(32'h3 | B_SWR | (32'hF << 18)));
        rd(1, v); chk("R13 status cleared", v, 32'h0);
        rd(4, v); chk("R13 count cleared", v, 32'h0);
        rd(3, v); chk("R13 compare cleared", v, 32'h0);
        rd(2, v); chk("R13 load all-ones", v, 32'hFFFF_FFFF);

        finish_run();
    end

endmodule